// File: doc/BRIEF.md
# Clock Fan-out Divider

This block is the digital back end of a clock-multiplying loop. It takes a fast oscillator clock and two reference clocks. From a single source clock it builds a family of related clocks: five identical in-phase outputs, one output inverted against them, one at twice their rate and one at half their rate. The analog parts of the loop are not part of this block, and neither is lock detection.

The source clock has three possible origins:

- the oscillator itself;
- the oscillator divided by two, which halves every output frequency;
- in a test bypass mode, the selected reference clock directly. This lets the outputs be stepped at low speed or held static.

An active-low asynchronous reset clears the divider state. While reset is low, it floats every clock output. Integration logic can watch a separate drive-enable output that mirrors the output buffers' enable.

Top module: `clk_fanout_div`

## Requirements
- R1: `ref_pick` = 1 selects `ref1_clk` as the reference; `ref_pick` = 0 selects `ref0_clk`.
- R2: With `loop_en` = 0, the selected reference clocks the divider chain. With `loop_en` = 1, the oscillator path clocks it.
- R3: With `loop_en` = 1 and `prediv_en` = 1, the oscillator passes through a divide-by-two stage before the chain. Each source edge then takes two `osc_clk` rising edges, so every output runs at half the rate it has with `prediv_en` = 0.
- R4: With `loop_en` = 0, `prediv_en` has no effect on any output.
- R5: `q_dbl` toggles on every rising edge of the source clock.
- R6: The shared Q register toggles on each rising edge of the double-rate register. All `NUM_Q` bits of `q_out` carry that one register and are always equal.
- R7: `q_half` toggles on each rising edge of Q. Over a window that starts at reset release, the rising-edge counts of `q_dbl`, `q_out` and `q_half` are in the ratio 4:2:1.
- R8: While driven, `q_inv` is always the logical complement of `q_out`.
- R9: While `rst_n` is low, the divider registers are cleared without any clock. `drive_en` is 0 and all clock outputs are high-impedance. With `rst_n` high, `drive_en` is 1 and the outputs are driven.
- R10: After reset release, every output reads 0 until the first source rising edge. On that edge `q_dbl`, `q_out` and `q_half` all rise together. After k source edges, the outputs are:
  - `q_dbl` = k mod 2;
  - `q_out` = ((k+1)/2) mod 2;
  - `q_half` = ((k+3)/4) mod 2, using integer division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock |
| ref0_clk | input | 1 | Reference clock, choice 0 |
| ref1_clk | input | 1 | Reference clock, choice 1 |
| ref_pick | input | 1 | Reference select (1 picks ref1_clk) |
| prediv_en | input | 1 | Switches the divide-by-two into the oscillator path |
| loop_en | input | 1 | 1 uses the oscillator path, 0 bypasses to the reference |
| rst_n | input | 1 | Asynchronous active-low reset, also the output enable |
| q_out | output | NUM_Q | In-phase clock outputs |
| q_inv | output | 1 | Inverted copy of q_out |
| q_dbl | output | 1 | Double-rate clock output |
| q_half | output | 1 | Half-rate clock output |
| drive_en | output | 1 | High when the clock outputs are driven |

## Verification
The bench drives the divider from a known state and checks the outputs after exactly k source edges. This catches a chain that starts from the wrong phase, a stage that toggles on the wrong edge of its neighbour, or a half-rate register that misses its common rise with Q.

Edge counting over fixed windows separates the three clock origins:

- a prediv stage placed on the wrong path gives double or half the expected counts in oscillator or bypass mode;
- a swapped reference select gives counts tied to the wrong reference period.

Reset is dropped between clock edges, which exposes a synchronous clear or an enable derived from a clocked signal. Q and its inverse are compared in every random sample, so a stuck or non-inverted output is caught.

// File: rtl/clk_fanout_div.sv
module clk_fanout_div #(
  parameter int NUM_Q = 5
) (
  input  logic             osc_clk,
  input  logic             ref0_clk,
  input  logic             ref1_clk,
  input  logic             ref_pick,
  input  logic             prediv_en,
  input  logic             loop_en,
  input  logic             rst_n,
  output logic [NUM_Q-1:0] q_out,
  output logic             q_inv,
  output logic             q_dbl,
  output logic             q_half,
  output logic             drive_en
);

  logic osc_half;
  logic ref_clk;
  logic osc_path;
  logic src_clk;
  logic dbl_r;
  logic q_r;
  logic half_r;

  // R1: reference choice
  assign ref_clk  = ref_pick ? ref1_clk : ref0_clk;

  // R3: optional divide-by-two in the oscillator path only
  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n) osc_half <= 1'b0;
    else        osc_half <= ~osc_half;

  assign osc_path = prediv_en ? osc_half : osc_clk;

  // R2, R4: bypass picks the reference and ignores the pre-divide
  assign src_clk  = loop_en ? osc_path : ref_clk;

  // R5: double-rate stage
  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) dbl_r <= 1'b0;
    else        dbl_r <= ~dbl_r;

  // R6: shared Q stage
  always_ff @(posedge dbl_r or negedge rst_n)
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= ~q_r;

  // R7: half-rate stage
  always_ff @(posedge q_r or negedge rst_n)
    if (!rst_n) half_r <= 1'b0;
    else        half_r <= ~half_r;

  // R9: enable comes straight from the reset pin
  assign drive_en = rst_n;
  assign q_dbl    = drive_en ? dbl_r  : 1'bz;
  assign q_half   = drive_en ? half_r : 1'bz;
  assign q_inv    = drive_en ? ~q_r   : 1'bz;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_Q; gi++) begin : g_qout
      assign q_out[gi] = drive_en ? q_r : 1'bz;
    end
  endgenerate

  // R6
  q_follows_dbl_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(q_r) |-> $rose(dbl_r));

  // R7
  half_follows_q_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(half_r) |-> $rose(q_r));

  // R10
  half_rise_dbl_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(half_r) |-> $rose(dbl_r));

  // R9
  reset_clear_chk: assert property (@(posedge osc_clk)
    !rst_n |-> (!dbl_r && !q_r && !half_r && !osc_half));

endmodule

// File: tb/clk_fanout_div_bench.sv
`timescale 1ns/1ps
module clk_fanout_div_bench;
  localparam int NQ = 5;

  logic osc_clk = 1'b0, ref0_clk = 1'b0, ref1_clk = 1'b0;
  logic ref_pick = 1'b0, prediv_en = 1'b0, loop_en = 1'b1, rst_n = 1'b0;
  logic [NQ-1:0] q_out;
  logic q_inv, q_dbl, q_half, drive_en;

  int checks = 0, fails = 0;
  bit done = 0;

  clk_fanout_div #(.NUM_Q(NQ)) u_clk_fanout_div (
    .osc_clk(osc_clk), .ref0_clk(ref0_clk), .ref1_clk(ref1_clk),
    .ref_pick(ref_pick), .prediv_en(prediv_en), .loop_en(loop_en),
    .rst_n(rst_n), .q_out(q_out), .q_inv(q_inv), .q_dbl(q_dbl),
    .q_half(q_half), .drive_en(drive_en)
  );

  always #2 osc_clk = ~osc_clk;
  initial begin #1; forever #12 ref0_clk = ~ref0_clk; end
  initial begin #3; forever #20 ref1_clk = ~ref1_clk; end

  logic div_m, src_m;
  always @(posedge osc_clk or negedge rst_n)
    if (!rst_n) div_m <= 1'b0; else div_m <= ~div_m;
  assign src_m = loop_en ? (prediv_en ? div_m : osc_clk) : (ref_pick ? ref1_clk : ref0_clk);

  int cd, cq, ch;
  always @(posedge q_dbl or negedge rst_n)    if (!rst_n) cd <= 0; else cd <= cd + 1;
  always @(posedge q_out[0] or negedge rst_n) if (!rst_n) cq <= 0; else cq <= cq + 1;
  always @(posedge q_half or negedge rst_n)   if (!rst_n) ch <= 0; else ch <= ch + 1;

  function automatic logic [7:0] exp_vec(int k);
    logic d, q, h;
    d = logic'(k % 2);
    q = logic'(((k + 1) / 2) % 2);
    h = logic'(((k + 3) / 4) % 2);
    return {h, ~q, {NQ{q}}, d};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start(logic lp, logic pd, logic rp);
    rst_n = 1'b0;
    loop_en = lp; prediv_en = pd; ref_pick = rp;
    #3;
    @(negedge osc_clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] outs();
    return {q_half, q_inv, q_out, q_dbl};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    // R9: reset state
    repeat (5) @(negedge osc_clk);
    check("R9 drive_en low in reset", 32'(drive_en), 32'd0);

    // R10: quiet after release, R7 ratio over a window
    start(1'b1, 1'b0, 1'b0);
    #1;
    check("R10 outputs zero after release", 32'(outs()), 32'(exp_vec(0)));
    check("R9 drive_en high", 32'(drive_en), 32'd1);
    repeat (64) @(posedge src_m);
    #1;
    check("R7 dbl rises", 32'(cd), 32'd32);
    check("R7 q rises",   32'(cq), 32'd16);
    check("R7 half rises", 32'(ch), 32'd8);

    // R3: pre-divide halves the rate
    start(1'b1, 1'b1, 1'b0);
    repeat (32) @(posedge osc_clk);
    #1;
    check("R3 prediv dbl rises", 32'(cd), 32'd8);
    start(1'b1, 1'b0, 1'b0);
    repeat (32) @(posedge osc_clk);
    #1;
    check("R3 no prediv dbl rises", 32'(cd), 32'd16);

    // R1, R2: bypass follows the chosen reference
    start(1'b0, 1'b0, 1'b0);
    repeat (16) @(posedge ref0_clk);
    #1;
    check("R1 R2 ref0 dbl rises", 32'(cd), 32'd8);
    check("R2 ref0 half rises", 32'(ch), 32'd2);
    start(1'b0, 1'b0, 1'b1);
    repeat (16) @(posedge ref1_clk);
    #1;
    check("R1 R2 ref1 q rises", 32'(cq), 32'd4);

    // R4: prediv ignored in bypass
    start(1'b0, 1'b1, 1'b1);
    repeat (16) @(posedge ref1_clk);
    #1;
    check("R4 bypass prediv dbl rises", 32'(cd), 32'd8);
    check("R4 bypass prediv state", 32'(outs()), 32'(exp_vec(16)));

    // R9, R10: async reset between edges
    start(1'b1, 1'b0, 1'b0);
    repeat (7) @(posedge osc_clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R9 async disable", 32'(drive_en), 32'd0);
    #0.2;
    rst_n = 1'b1;
    #0.2;
    check("R9 R10 async clear", 32'(outs()), 32'(exp_vec(0)));

    // R5 R6 R8 R10: random modes and edge counts
    for (int it = 0; it < 40; it++) begin
      int k;
      k = 1 + int'($urandom_range(39));
      start(logic'($urandom_range(1)), logic'($urandom_range(1)), logic'($urandom_range(1)));
      repeat (k) @(posedge src_m);
      #1;
      check("R5 R6 R8 R10 chain state", 32'(outs()), 32'(exp_vec(k)));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule